// File: doc/BRIEF.md
# Two-Wire Switch Register Read Master

This block reads one 16-bit register from a switch chip over a two-wire serial management bus. The bus has a clock that only the master drives and a single data line that both sides share. The host starts a read by pulsing `req` together with a command byte and a 16-bit register address. The block then runs the whole frame by itself and returns the register contents with a one-cycle `done` pulse.

Each frame has a fixed number of bit slots. There is no run of leading ones. The frame opens with a three-bit start mark, then sends the command byte and the address, low byte first. After one turnaround slot the master releases the data line, and the slave sends back two data bytes, low byte first. The master then drives a two-bit stop mark and gives one extra clock pulse. The command byte comes from the host, so chip variants with a different read opcode can use the same block.

The bus clock is derived from the system clock. Each bit slot lasts `DIV` system cycles with the clock low and then `DIV` cycles with the clock high. Outgoing bits change only while the clock is low. Incoming bits are captured at the rising edge of the bus clock.

Top module: `swmgmt_rd_master`

## Requirements
- R1: After reset, and whenever no frame is running, `busy`, `done`, `bus_clk` and `bus_oe` are 0, `bus_dout` is 0 and `rdata` keeps its last value (0 after reset).
- R2: A frame accepted at a rising clock edge starts in the next cycle with slots 0, 1 and 2 driving 1, 0, 1 with `bus_oe`=1. No preamble comes first.
- R3: Slots 3 to 10 drive the command byte, most significant bit first, with `bus_oe`=1.
- R4: Slots 11 to 18 drive address bits [7:0] and slots 19 to 26 drive address bits [15:8], each byte most significant bit first, with `bus_oe`=1.
- R5: Slot 27 (turnaround) and the data slots 28 to 43 have `bus_oe`=0.
- R6: The bit on `bus_din` at the end of the low half of data slot 28+j is captured. Slots 28 to 35 carry `rdata[7:0]` and slots 36 to 43 carry `rdata[15:8]`, each byte most significant bit first.
- R7: Slot 44 drives 0 and slot 45 drives 1, both with `bus_oe`=1.
- R8: Slot 46 is one more bus clock pulse with the line driven to 1. After it, the bus goes idle.
- R9: In every slot, `bus_clk` is low for `DIV` system cycles and then high for `DIV` cycles. It is low while idle.
- R10: `busy` is 1 for exactly 47*2*`DIV` cycles. In the cycle after the last one, `done` is 1 for exactly one cycle, `busy` is 0, and `rdata` holds the new value.
- R11: A `req` raised while `busy` is 1 has no effect. The frame in progress, its result, and the idle state that follows are all unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request strobe, accepted only while idle |
| cmd | input | 8 | Command byte sent after the start mark |
| addr | input | 16 | Register address |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when rdata is valid |
| rdata | output | 16 | Register value read back |
| bus_clk | output | 1 | Bus clock, low while idle |
| bus_dout | output | 1 | Data line output value |
| bus_oe | output | 1 | Data line output enable |
| bus_din | input | 1 | Data line input value |

## Verification
The hardest condition to create from the ports is a request that arrives in the middle of a frame. It must be dropped without disturbing the frame's timing, the bits already latched, or the bits still captured from the slave. To reach it, the bench raises `req` during the address phase with an inverted command and address, then compares every remaining slot and the returned word against the model of the original request. The slave side is also driven with patterns whose byte halves differ, such as 0x8000 and 0x0001, so that a swapped byte order or a reversed bit order inside a byte shows up in `rdata`.

// File: rtl/swmgmt_pkg.sv
package swmgmt_pkg;
  localparam int SLOT_W      = 6;
  localparam int SL_CMD      = 3;
  localparam int SL_TURN     = 27;
  localparam int SL_DATA     = 28;
  localparam int SL_STOP     = 44;
  localparam int SL_LAST     = 46;
  localparam int NUM_SLOTS   = SL_LAST + 1;
  localparam int TX_BITS     = SL_TURN;
  localparam int RX_BITS     = SL_STOP - SL_DATA;

  typedef enum logic [1:0] {
    PH_DRIVE   = 2'd0,
    PH_RELEASE = 2'd1,
    PH_STOP0   = 2'd2,
    PH_HIGH    = 2'd3
  } slot_phase_e;

  function automatic slot_phase_e phase_of(input logic [SLOT_W-1:0] s);
    if (s < SLOT_W'(SL_TURN))      return PH_DRIVE;
    else if (s < SLOT_W'(SL_STOP)) return PH_RELEASE;
    else if (s == SLOT_W'(SL_STOP)) return PH_STOP0;
    else                           return PH_HIGH;
  endfunction
endpackage

// File: rtl/swmgmt_half_tick.sv
module swmgmt_half_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)            cnt_d = '0;
    else if (cnt_q == TOP) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == TOP);
endmodule

// File: rtl/swmgmt_tx_shift.sv
module swmgmt_tx_shift #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = load_val;
    else if (shift) sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/swmgmt_rx_shift.sv
module swmgmt_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (clear)      sr_d = '0;
    else if (shift) sr_d = {sr_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q;
endmodule

// File: rtl/swmgmt_rd_master.sv
module swmgmt_rd_master #(
  parameter int DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [7:0]  cmd,
  input  logic [15:0] addr,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        bus_clk,
  output logic        bus_dout,
  output logic        bus_oe,
  input  logic        bus_din
);
  import swmgmt_pkg::*;

  localparam int BYTE_W = RX_BITS / 2;

  logic                run_q, run_d;
  logic                half_q, half_d;
  logic [SLOT_W-1:0]   slot_q, slot_d;
  logic                done_q, done_d;
  logic [RX_BITS-1:0]  rdata_q, rdata_d;

  logic                tick;
  logic                start;
  logic                tx_msb;
  logic                tx_shift_en;
  logic                rx_shift_en;
  logic [RX_BITS-1:0]  rx_word;
  logic [TX_BITS-1:0]  tx_frame;
  logic                in_data;
  slot_phase_e         ph;

  assign start    = req && !run_q;
  assign tx_frame = {3'b101, cmd, addr[7:0], addr[15:8]};
  assign in_data  = (slot_q >= SLOT_W'(SL_DATA)) && (slot_q < SLOT_W'(SL_STOP));

  assign tx_shift_en = run_q && tick && half_q && (slot_q < SLOT_W'(SL_TURN));
  assign rx_shift_en = run_q && tick && !half_q && in_data;

  swmgmt_half_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q),
    .tick (tick)
  );

  swmgmt_tx_shift #(.W(TX_BITS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .load_val(tx_frame),
    .shift   (tx_shift_en),
    .msb     (tx_msb)
  );

  swmgmt_rx_shift #(.W(RX_BITS)) u_rx (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(start),
    .shift(rx_shift_en),
    .din  (bus_din),
    .q    (rx_word)
  );

  always_comb begin
    run_d   = run_q;
    half_d  = half_q;
    slot_d  = slot_q;
    done_d  = 1'b0;
    rdata_d = rdata_q;
    if (start) begin
      run_d  = 1'b1;
      half_d = 1'b0;
      slot_d = '0;
    end else if (run_q && tick) begin
      if (!half_q) begin
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
        if (slot_q == SLOT_W'(SL_LAST)) begin
          run_d   = 1'b0;
          slot_d  = '0;
          done_d  = 1'b1;
          rdata_d = {rx_word[BYTE_W-1:0], rx_word[RX_BITS-1:BYTE_W]};
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      half_q  <= 1'b0;
      slot_q  <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      run_q   <= run_d;
      half_q  <= half_d;
      slot_q  <= slot_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  assign ph = phase_of(slot_q);

  always_comb begin
    bus_oe   = 1'b0;
    bus_dout = 1'b0;
    if (run_q) begin
      unique case (ph)
        PH_DRIVE:   begin bus_oe = 1'b1; bus_dout = tx_msb; end
        PH_RELEASE: begin bus_oe = 1'b0; bus_dout = 1'b0;   end
        PH_STOP0:   begin bus_oe = 1'b1; bus_dout = 1'b0;   end
        PH_HIGH:    begin bus_oe = 1'b1; bus_dout = 1'b1;   end
        default:    begin bus_oe = 1'b0; bus_dout = 1'b0;   end
      endcase
    end
  end

  assign bus_clk = half_q;
  assign busy    = run_q;
  assign done    = done_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/swmgmt_rd_master_chk.sv
module swmgmt_rd_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdata,
  input logic        bus_clk,
  input logic        bus_oe,
  input logic        bus_dout
);
  p_idle_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_oe && !bus_dout));

  p_idle_clk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_clk);

  p_clk_rise_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_clk) |-> busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));
endmodule

bind swmgmt_rd_master swmgmt_rd_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .rdata   (rdata),
  .bus_clk (bus_clk),
  .bus_oe  (bus_oe),
  .bus_dout(bus_dout)
);

// File: tb/sim_swmgmt_rd_master.sv
module sim_swmgmt_rd_master;
  localparam int DIV   = 2;
  localparam int SLOTS = 47;
  localparam int TOTAL = SLOTS * 2 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [7:0]  cmd = 8'h00;
  logic [15:0] addr = 16'h0000;
  logic        busy, done, bus_clk, bus_dout, bus_oe;
  logic [15:0] rdata;
  logic        bus_din = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  swmgmt_rd_master #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .cmd(cmd), .addr(addr),
    .busy(busy), .done(done), .rdata(rdata),
    .bus_clk(bus_clk), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int s);
    if (s < 3)        return "R2 start";
    else if (s < 11)  return "R3 command";
    else if (s < 27)  return "R4 address";
    else if (s < 44)  return "R5 release";
    else if (s < 46)  return "R7 stop";
    else              return "R8 extra pulse";
  endfunction

  task automatic check_idle(input string tag);
    chk(busy == 1'b0,    {tag, " busy"},  busy,    0);
    chk(done == 1'b0,    {tag, " done"},  done,    0);
    chk(bus_clk == 1'b0, {tag, " clk"},   bus_clk, 0);
    chk(bus_oe == 1'b0,  {tag, " oe"},    bus_oe,  0);
    chk(bus_dout == 1'b0,{tag, " dout"},  bus_dout,0);
  endtask

  task automatic run_txn(input logic [7:0] c, input logic [15:0] a,
                         input logic [15:0] d, input bit poke);
    logic exp_bit[$];
    logic exp_oe[$];
    logic din_q[$];
    for (int i = 0; i < 3; i++) begin exp_bit.push_back(i != 1); exp_oe.push_back(1'b1); end
    for (int i = 7; i >= 0; i--) begin exp_bit.push_back(c[i]); exp_oe.push_back(1'b1); end
    for (int i = 7; i >= 0; i--) begin exp_bit.push_back(a[i]); exp_oe.push_back(1'b1); end
    for (int i = 15; i >= 8; i--) begin exp_bit.push_back(a[i]); exp_oe.push_back(1'b1); end
    for (int i = 0; i < 17; i++) begin exp_bit.push_back(1'b0); exp_oe.push_back(1'b0); end
    exp_bit.push_back(1'b0); exp_oe.push_back(1'b1);
    exp_bit.push_back(1'b1); exp_oe.push_back(1'b1);
    exp_bit.push_back(1'b1); exp_oe.push_back(1'b1);
    for (int i = 7; i >= 0; i--) din_q.push_back(d[i]);
    for (int i = 15; i >= 8; i--) din_q.push_back(d[i]);

    @(negedge clk);
    req = 1'b1; cmd = c; addr = a;
    for (int k = 0; k <= TOTAL; k++) begin
      @(negedge clk);
      req = 1'b0;
      if (poke && k == 50) begin
        req = 1'b1; cmd = ~c; addr = ~a;   // R11 mid-frame request
      end
      if (k < TOTAL) begin
        int s = k / (2 * DIV);
        int h = (k / DIV) % 2;
        bus_din = (s >= 28 && s < 44) ? din_q[s - 28] : ~bus_din;
        chk(bus_clk == h[0], "R9 bus clock", bus_clk, h);
        chk(busy == 1'b1, "R10 busy", busy, 1);
        chk(done == 1'b0, "R10 done early", done, 0);
        chk(bus_oe == exp_oe[s], {tag_of(s), " oe"}, bus_oe, exp_oe[s]);
        if (exp_oe[s])
          chk(bus_dout == exp_bit[s], {tag_of(s), " data"}, bus_dout, exp_bit[s]);
      end else begin
        chk(done == 1'b1, "R10 done pulse", done, 1);
        chk(busy == 1'b0, "R10 busy end", busy, 0);
        chk(rdata == d, "R6 read data", rdata, d);
        chk(bus_clk == 1'b0 && bus_oe == 1'b0, "R8 idle after pulse", {bus_clk, bus_oe}, 0);
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    check_idle(poke ? "R11 no restart" : "R1 idle");
    chk(rdata == d, "R1 rdata held", rdata, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    chk(rdata == 16'h0, "R1 reset rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 after reset");

    run_txn(8'hA9, 16'h1234, 16'hBEEF, 1'b0);
    run_txn(8'h3C, 16'h00FF, 16'h0001, 1'b0);
    run_txn(8'hA9, 16'hFF00, 16'h8000, 1'b1);
    run_txn(8'h00, 16'h0000, 16'h0000, 1'b0);
    run_txn(8'hFF, 16'hFFFF, 16'hFFFF, 1'b0);
    run_txn(8'h5A, 16'hA55A, 16'h1EF0, 1'b1);

    repeat (5) @(negedge clk);
    check_idle("R1 final idle");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule